// File: doc/BRIEF.md
# Two-Half Interrupt Flag Controller

This block gathers interrupt requests for a single processor. Up to 32 peripheral sources each own one request line. A pulse on a line latches into a 32-bit pending-flag register. A 32-bit enable register and a one-bit global gate decide whether the processor sees an interrupt. Software reaches both 32-bit registers through a 16-bit register bus, one half at a time. Pending flags are cleared by writing ones to them.

The block drives two outputs toward the processor. The interrupt line is a level, and it stays high while the global gate is set and at least one pending flag is also enabled. The wake pulse brings a halted core back to life. It depends only on the per-source enables, so a core that sleeps with the global gate closed still wakes when an enabled source fires. Because the interrupt output is computed from the stored state, any write to an enable half or to the gate takes effect on the very next cycle, with no separate re-check step.

Top module: `intc_top`

## Requirements
- R1: After synchronous reset all enable bits, all flag bits and the global gate are zero, `irq_o` is low and `wake_o` is low.
- R2: A pulse on `src_pulse[i]` sets flag bit i on the next clock edge, whatever the enable and gate state. Lines 0 to 15 land in the low flag half (address 2), and lines 16 to 31 land in the high flag half (address 3) at bit i-16.
- R3: A write to a flag half clears each bit written as 1 and leaves each bit written as 0 unchanged. If a source pulse arrives in the same cycle as the clear of its bit, the bit stays set.
- R4: `irq_o` is high exactly when the gate bit is 1 and the AND of the 32 enable bits with the 32 flag bits is non-zero. It is a level that holds while that condition holds.
- R5: While the gate bit is 0, `irq_o` stays low whatever the flags and enables are.
- R6: A write to an enable half, or a write that sets the gate, raises `irq_o` in the cycle after the write if enabled flags are already pending.
- R7: `wake_o` is high for one cycle after each cycle in which a source with its enable bit set pulses, whether or not the gate is set. A pulse on a disabled source gives no wake.
- R8: The gate register (address 4) stores only write-data bit 0 and reads back with bits 15:1 as zero. A write of 0xFFFE therefore closes the gate.
- R9: Register map on `bus_addr`: 0 is the low enable half, 1 is the high enable half, 2 is the low flag half, 3 is the high flag half, 4 is the gate. `bus_rdata` follows the address combinationally. Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| src_pulse | input | 32 | Request lines, one per source |
| irq_o | output | 1 | Interrupt level to the processor |
| wake_o | output | 1 | One-cycle halt wake pulse |

## Verification
Corrupted state shows up at the ports within one cycle. A flag bit that fails to latch, or that is cleared by the wrong write, is visible on the next read of its half. It is also visible on `irq_o` in that same cycle whenever its enable bit and the gate are set. A gate or enable bit stuck in the wrong value shows either as an interrupt asserted with the gate closed or as a missing wake pulse one edge after an enabled source fires. The sweep drives every source under every combination of its enable bit and the gate, so a wrong half, bit position or gate dependency is exposed directly.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [1:0] {
        SEL_EN   = 2'd0,
        SEL_FLG  = 2'd1,
        SEL_GATE = 2'd2,
        SEL_NONE = 2'd3
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    // Map: enable halves first, then flag halves, then the gate register.
    function automatic reg_sel_t decode_addr(input logic [7:0] addr, input int halves);
        reg_sel_t s;
        int a;
        a = int'(addr);
        s.kind = SEL_NONE;
        s.idx  = 8'd0;
        if (a < halves) begin
            s.kind = SEL_EN;
            s.idx  = 8'(a);
        end else if (a < 2 * halves) begin
            s.kind = SEL_FLG;
            s.idx  = 8'(a - halves);
        end else if (a == 2 * halves) begin
            s.kind = SEL_GATE;
        end
        return s;
    endfunction

    function automatic logic [7:0] gate_addr(input int halves);
        return 8'(2 * halves);
    endfunction

endpackage

// File: rtl/intc_half_bank.sv
module intc_half_bank #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_we,
    input  logic              flg_we,
    input  logic [HALF_W-1:0] wdata,
    input  logic [HALF_W-1:0] src,
    output logic [HALF_W-1:0] en_q,
    output logic [HALF_W-1:0] flg_q
);
    logic [HALF_W-1:0] clr_mask;

    always_comb begin
        clr_mask = flg_we ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_we) begin
            en_q <= wdata;
        end
    end

    // A pulse arriving together with a clear of the same bit keeps the bit set.
    always_ff @(posedge clk) begin
        if (rst) begin
            flg_q <= '0;
        end else begin
            flg_q <= (flg_q & ~clr_mask) | src;
        end
    end
endmodule

// File: rtl/intc_gate_reg.sv
module intc_gate_reg (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wbit,
    output logic gate_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
        end else if (we) begin
            gate_q <= wbit;
        end
    end
endmodule

// File: rtl/intc_event_gen.sv
module intc_event_gen #(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] en,
    input  logic [SRC_W-1:0] flg,
    input  logic [SRC_W-1:0] src,
    input  logic             gate,
    output logic             irq,
    output logic             wake
);
    logic any_pending;
    logic wake_d;

    always_comb begin
        any_pending = |(en & flg);
        irq         = gate & any_pending;
        wake_d      = |(en & src);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake <= 1'b0;
        end else begin
            wake <= wake_d;
        end
    end
endmodule

// File: rtl/intc_top.sv
module intc_top #(
    parameter int HALF_W     = 16,
    parameter int NUM_HALVES = 2,
    parameter int ADDR_W     = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [HALF_W-1:0]            bus_wdata,
    output logic [HALF_W-1:0]            bus_rdata,
    input  logic [HALF_W*NUM_HALVES-1:0] src_pulse,
    output logic                         irq_o,
    output logic                         wake_o
);
    import intc_pkg::*;

    localparam int SRC_W = HALF_W * NUM_HALVES;
    localparam int IDX_W = (NUM_HALVES > 1) ? $clog2(NUM_HALVES) : 1;

    reg_sel_t          sel;
    logic [HALF_W-1:0] en_half  [NUM_HALVES];
    logic [HALF_W-1:0] flg_half [NUM_HALVES];
    logic [SRC_W-1:0]  en_all;
    logic [SRC_W-1:0]  flg_all;
    logic              gate_q;
    logic              gate_we;

    always_comb begin
        sel     = decode_addr(8'(bus_addr), NUM_HALVES);
        gate_we = bus_wr && (sel.kind == SEL_GATE);
    end

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        logic en_we_h;
        logic flg_we_h;

        always_comb begin
            en_we_h  = bus_wr && (sel.kind == SEL_EN)  && (sel.idx == 8'(h));
            flg_we_h = bus_wr && (sel.kind == SEL_FLG) && (sel.idx == 8'(h));
        end

        intc_half_bank #(.HALF_W(HALF_W)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .en_we  (en_we_h),
            .flg_we (flg_we_h),
            .wdata  (bus_wdata),
            .src    (src_pulse[h*HALF_W +: HALF_W]),
            .en_q   (en_half[h]),
            .flg_q  (flg_half[h])
        );

        assign en_all[h*HALF_W +: HALF_W]  = en_half[h];
        assign flg_all[h*HALF_W +: HALF_W] = flg_half[h];
    end

    intc_gate_reg u_gate (
        .clk    (clk),
        .rst    (rst),
        .we     (gate_we),
        .wbit   (bus_wdata[0]),
        .gate_q (gate_q)
    );

    intc_event_gen #(.SRC_W(SRC_W)) u_evt (
        .clk  (clk),
        .rst  (rst),
        .en   (en_all),
        .flg  (flg_all),
        .src  (src_pulse),
        .gate (gate_q),
        .irq  (irq_o),
        .wake (wake_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel.kind)
            SEL_EN:   bus_rdata = en_half[sel.idx[IDX_W-1:0]];
            SEL_FLG:  bus_rdata = flg_half[sel.idx[IDX_W-1:0]];
            SEL_GATE: bus_rdata = {{(HALF_W-1){1'b0}}, gate_q};
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int HALF_W     = 16,
    parameter int NUM_HALVES = 2,
    parameter int ADDR_W     = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic [HALF_W-1:0]            bus_wdata,
    input logic [HALF_W-1:0]            bus_rdata,
    input logic [HALF_W*NUM_HALVES-1:0] src_pulse,
    input logic [HALF_W*NUM_HALVES-1:0] en_all,
    input logic [HALF_W*NUM_HALVES-1:0] flg_all,
    input logic                         gate_q,
    input logic                         irq_o,
    input logic                         wake_o
);
    localparam int GATE_A = 2 * NUM_HALVES;
    localparam int FLG0_A = NUM_HALVES;

    AST_GATE_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        !gate_q |-> !irq_o); // R5

    AST_SRC_LATCHES: assert property (@(posedge clk) disable iff (rst)
        (src_pulse != '0) |=> ((flg_all & $past(src_pulse)) == $past(src_pulse))); // R2

    AST_CLEAR_LOW_HALF: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr) == FLG0_A) |=>
        ((flg_all[HALF_W-1:0] & $past(bus_wdata & ~src_pulse[HALF_W-1:0])) == '0)); // R3

    AST_WAKE_ON_ENABLED: assert property (@(posedge clk) disable iff (rst)
        ((src_pulse & en_all) != '0) |=> wake_o); // R7

    AST_NO_WAKE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        ((src_pulse & en_all) == '0) |=> !wake_o); // R7

    AST_GATE_REEVAL: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && int'(bus_addr) == GATE_A && bus_wdata[0] && ((en_all & flg_all) != '0))
        |=> irq_o); // R6

    AST_GATE_READ_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (int'(bus_addr) == GATE_A) |-> (bus_rdata[HALF_W-1:1] == '0)); // R8
endmodule

bind intc_top intc_checker #(
    .HALF_W     (HALF_W),
    .NUM_HALVES (NUM_HALVES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_pulse (src_pulse),
    .en_all    (en_all),
    .flg_all   (flg_all),
    .gate_q    (gate_q),
    .irq_o     (irq_o),
    .wake_o    (wake_o)
);

// File: tb/intc_top_tb.sv
module intc_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic [31:0] src_pulse = 32'd0;
    logic        irq_o;
    logic        wake_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    intc_top u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pulse (src_pulse),
        .irq_o     (irq_o),
        .wake_o    (wake_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [31:0] s);
        @(negedge clk);
        src_pulse = s;
        @(negedge clk);
        src_pulse = 32'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), rv);
            check("R1 reg after reset", {16'd0, rv}, 32'd0);
        end
        check("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        check("R1 wake after reset", {31'd0, wake_o}, 32'd0);

        // Sweep: every source under every enable/gate combination.
        for (int i = 0; i < 32; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic        en_on;
                logic        gt_on;
                logic [31:0] en_v;
                logic [15:0] bitv;
                logic [2:0]  fa;
                en_on = m[0];
                gt_on = m[1];
                en_v  = en_on ? (32'd1 << i) : ~(32'd1 << i);
                bitv  = 16'd1 << (i % 16);
                fa    = (i < 16) ? 3'd2 : 3'd3;
                wr(3'd4, gt_on ? 16'hFFFF : 16'hFFFE);
                rd(3'd4, rv);
                check("R8 gate readback", {16'd0, rv}, {31'd0, gt_on});
                wr(3'd0, en_v[15:0]);
                wr(3'd1, en_v[31:16]);
                wr(3'd2, 16'hFFFF);
                wr(3'd3, 16'hFFFF);
                check("R4 no irq with flags clear", {31'd0, irq_o}, 32'd0);
                pulse(32'd1 << i);
                check("R7 wake after pulse", {31'd0, wake_o}, {31'd0, en_on});
                rd(fa, rv);
                check("R2 flag half bit set", {16'd0, rv}, {16'd0, bitv});
                rd(fa ^ 3'd1, rv);
                check("R2 other flag half untouched", {16'd0, rv}, 32'd0);
                check("R4 R5 irq level", {31'd0, irq_o}, {31'd0, en_on & gt_on});
                @(negedge clk);
                check("R7 wake single cycle", {31'd0, wake_o}, 32'd0);
                check("R4 irq held", {31'd0, irq_o}, {31'd0, en_on & gt_on});
                wr(fa, bitv);
                rd(fa, rv);
                check("R3 w1c clears bit", {16'd0, rv}, 32'd0);
                check("R4 irq drops after clear", {31'd0, irq_o}, 32'd0);
            end
        end

        // R3: writing zeros leaves flags, and a same-cycle pulse beats a clear.
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
        pulse(32'h0005_00A0);
        wr(3'd2, 16'h0000);
        rd(3'd2, rv);
        check("R3 zero write keeps flags", {16'd0, rv}, 32'h00A0);
        @(negedge clk);
        src_pulse = 32'h0000_0020;
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 16'h00A0;
        @(negedge clk);
        bus_wr = 1'b0; src_pulse = 32'd0;
        rd(3'd2, rv);
        check("R3 pulse wins over clear", {16'd0, rv}, 32'h0020);

        // R6: enable write re-evaluates pending flags (high half bit 2 pending).
        wr(3'd4, 16'h0001);
        check("R5 gate open, nothing enabled", {31'd0, irq_o}, 32'd0);
        wr(3'd1, 16'h0004);
        check("R6 irq after enable write", {31'd0, irq_o}, 32'd1);
        wr(3'd4, 16'h0000);
        check("R5 gate closed blocks irq", {31'd0, irq_o}, 32'd0);
        wr(3'd4, 16'h0001);
        check("R6 irq after gate set", {31'd0, irq_o}, 32'd1);
        wr(3'd4, 16'h0002);
        check("R8 only bit0 of gate counts", {31'd0, irq_o}, 32'd0);

        // R7: wake ignores gate (gate is closed here).
        pulse(32'h0004_0000);
        check("R7 wake with gate closed", {31'd0, wake_o}, 32'd1);

        // R9: unmapped addresses read zero and writes change nothing.
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 16'hFFFF);
            rd(3'(a), rv);
            check("R9 unmapped reads zero", {16'd0, rv}, 32'd0);
        end
        rd(3'd0, rv); check("R9 en lo intact", {16'd0, rv}, 32'h0000);
        rd(3'd1, rv); check("R9 en hi intact", {16'd0, rv}, 32'h0004);
        rd(3'd2, rv); check("R9 flg lo intact", {16'd0, rv}, 32'h0020);
        rd(3'd3, rv); check("R9 flg hi intact", {16'd0, rv}, 32'h0005);
        rd(3'd4, rv); check("R9 gate intact", {16'd0, rv}, 32'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule